// File: doc/BRIEF.md
# Telemetry Threshold Protection Monitor

This block watches sensor samples that arrive from elsewhere on the board and decides when the card must be powered off. Two 12 V supply inputs, the auxiliary and the edge-connector feed, arrive as unsigned millivolt counts. The FPGA core temperature and the board temperature arrive as signed integers in half-degree units, so a count of 200 means 100 °C. Each input has its own valid strobe. A sample is evaluated only in a cycle where its strobe is high, which lets an absent or unplugged sensor be ignored.

The supplies trip on undervoltage against a fixed limit. Each temperature has a warning limit and a fatal limit, and all four temperature limits can be written at run time. Any fatal condition sets a shutdown request. That request stays latched, together with a record of the conditions that caused it, until a clear pulse arrives at a time when no fatal condition remains. The block does not sequence rails itself. It only raises the request and reports the flags.

Top module: `tlm_guard`

## Requirements
- R1: A synchronous active-high reset clears every warning flag, every fatal flag, the shutdown request and the trip cause. It loads the temperature limits with their defaults: FPGA warning 180, FPGA fatal 200, board warning 150, board fatal 170 (half-degree units).
- R2: A valid supply sample strictly below 10460 mV sets its fatal flag one cycle later, and a sample of 10460 mV or more clears it. Bit 0 of `fatal_flags` is the auxiliary input and bit 1 is the edge input.
- R3: A valid FPGA temperature greater than or equal to the FPGA fatal limit sets `fatal_flags` bit 2 one cycle later. A value one below the limit does not set it.
- R4: A valid board temperature greater than or equal to the board fatal limit sets `fatal_flags` bit 3 one cycle later.
- R5: A valid temperature at or above its warning limit sets its warning flag (bit 0 FPGA, bit 1 board) one cycle later. A warning alone never raises the shutdown request.
- R6: Temperatures and limits are compared as two's-complement signed values, so a negative reading never reaches a positive limit.
- R7: When `lim_we` is high, `lim_wdata` is written to the limit that `lim_sel` selects: 0 FPGA warning, 1 FPGA fatal, 2 board warning, 3 board fatal. The new value governs samples from the next cycle on. A sample in the write cycle is judged against the old limit.
- R8: While a sensor's valid strobe is low, its sample has no effect and its flags keep their previous values.
- R9: `shutdown_req` rises in the cycle after any fatal flag is seen set. It stays high after the fatal flags clear.
- R10: A latched shutdown and its cause clear one cycle after `clr_trip` is high while all fatal flags are zero. A clear while any fatal flag is set has no effect.
- R11: When the shutdown latches, `trip_cause` takes the fatal flag vector of that cycle, so simultaneous causes are all recorded. It holds that value until the clear, and it is zero whenever no shutdown is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_mv | input | VW | Auxiliary 12 V supply sample, mV |
| aux_vld | input | 1 | Auxiliary sample valid |
| edge_mv | input | VW | Edge-connector 12 V supply sample, mV |
| edge_vld | input | 1 | Edge sample valid |
| fpga_temp | input | TW | FPGA core temperature, signed half-degrees |
| fpga_vld | input | 1 | FPGA temperature valid |
| brd_temp | input | TW | Board temperature, signed half-degrees |
| brd_vld | input | 1 | Board temperature valid |
| lim_we | input | 1 | Limit write enable |
| lim_sel | input | 2 | Limit select (0 FPGA warn, 1 FPGA fatal, 2 board warn, 3 board fatal) |
| lim_wdata | input | TW | Limit write value, signed half-degrees |
| clr_trip | input | 1 | Request to clear a latched shutdown |
| warn_flags | output | 2 | Warning flags: bit 0 FPGA, bit 1 board |
| fatal_flags | output | 4 | Fatal flags: aux UV, edge UV, FPGA OT, board OT |
| shutdown_req | output | 1 | Latched power-off request |
| trip_cause | output | 4 | Fatal vector captured when the shutdown latched |

## Verification
The bench probes the exact trip points: 10460 mV against 10459 mV, and each temperature limit against the value one below it. A wrong comparison operator would then trip one count early or late. A negative FPGA reading is applied to catch an unsigned compare, which would see a huge positive number and shut the card down. The bench also tries clearing while a fault persists, and expects the latch to hold. A design that cleared anyway would drop the request with a live fault. Simultaneous faults check that the cause records every bit. A limit write is made in the same cycle as a sample to catch a design that applies the new limit too early. A long randomized phase with invalid strobes then checks that an invalid sample never disturbs its flags.

// File: rtl/tlm_guard_pkg.sv
package tlm_guard_pkg;
  localparam int N_SUP   = 2;
  localparam int N_TEMP  = 2;
  localparam int N_FATAL = N_SUP + N_TEMP;
  localparam int SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    LIM_FPGA_WARN  = 2'd0,
    LIM_FPGA_FATAL = 2'd1,
    LIM_BRD_WARN   = 2'd2,
    LIM_BRD_FATAL  = 2'd3
  } lim_sel_e;
endpackage

// File: rtl/tlm_limit_regs.sv
module tlm_limit_regs
  import tlm_guard_pkg::*;
#(
  parameter int TW = 16,
  parameter logic [N_TEMP-1:0][TW-1:0] WARN_DEF  = '0,
  parameter logic [N_TEMP-1:0][TW-1:0] FATAL_DEF = '0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [SEL_W-1:0]             sel,
  input  logic [TW-1:0]                wdata,
  output logic [N_TEMP-1:0][TW-1:0]    warn_lim,
  output logic [N_TEMP-1:0][TW-1:0]    fatal_lim
);
  // sel[1] picks the channel, sel[0] picks fatal (1) or warning (0)
  for (genvar ch = 0; ch < N_TEMP; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        warn_lim[ch]  <= WARN_DEF[ch];
        fatal_lim[ch] <= FATAL_DEF[ch];
      end else if (we && (sel[1] == 1'(ch))) begin
        if (sel[0]) fatal_lim[ch] <= wdata;
        else        warn_lim[ch]  <= wdata;
      end
    end
  end
endmodule

// File: rtl/tlm_uv_chan.sv
module tlm_uv_chan #(
  parameter int VW    = 16,
  parameter int UV_MV = 10460
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [VW-1:0] sample,
  input  logic          vld,
  output logic          fatal
);
  localparam logic [VW-1:0] UV_LIM = VW'(UV_MV);

  always_ff @(posedge clk) begin
    if (rst)      fatal <= 1'b0;
    else if (vld) fatal <= (sample < UV_LIM);
  end
endmodule

// File: rtl/tlm_ot_chan.sv
module tlm_ot_chan #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] sample,
  input  logic          vld,
  input  logic [TW-1:0] warn_lim,
  input  logic [TW-1:0] fatal_lim,
  output logic          warn,
  output logic          fatal
);
  logic hit_warn, hit_fatal;

  always_comb begin
    hit_warn  = ($signed(sample) >= $signed(warn_lim));
    hit_fatal = ($signed(sample) >= $signed(fatal_lim));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      warn  <= 1'b0;
      fatal <= 1'b0;
    end else if (vld) begin
      warn  <= hit_warn;
      fatal <= hit_fatal;
    end
  end
endmodule

// File: rtl/tlm_trip_latch.sv
module tlm_trip_latch #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] fatal,
  input  logic          clr,
  output logic          shutdown,
  output logic [NF-1:0] cause
);
  logic any_fatal;
  assign any_fatal = |fatal;

  always_ff @(posedge clk) begin
    if (rst) begin
      shutdown <= 1'b0;
      cause    <= '0;
    end else if (!shutdown) begin
      if (any_fatal) begin
        shutdown <= 1'b1;
        cause    <= fatal;
      end
    end else if (clr && !any_fatal) begin
      shutdown <= 1'b0;
      cause    <= '0;
    end
  end
endmodule

// File: rtl/tlm_guard.sv
module tlm_guard
  import tlm_guard_pkg::*;
#(
  parameter int VW            = 16,
  parameter int TW            = 16,
  parameter int UV_MV         = 10460,
  parameter int FPGA_WARN_HD  = 180,
  parameter int FPGA_FATAL_HD = 200,
  parameter int BRD_WARN_HD   = 150,
  parameter int BRD_FATAL_HD  = 170
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [VW-1:0] aux_mv,
  input  logic          aux_vld,
  input  logic [VW-1:0] edge_mv,
  input  logic          edge_vld,
  input  logic [TW-1:0] fpga_temp,
  input  logic          fpga_vld,
  input  logic [TW-1:0] brd_temp,
  input  logic          brd_vld,
  input  logic          lim_we,
  input  logic [1:0]    lim_sel,
  input  logic [TW-1:0] lim_wdata,
  input  logic          clr_trip,
  output logic [1:0]    warn_flags,
  output logic [3:0]    fatal_flags,
  output logic          shutdown_req,
  output logic [3:0]    trip_cause
);
  localparam logic [N_TEMP-1:0][TW-1:0] WARN_DEF  = {TW'(BRD_WARN_HD),  TW'(FPGA_WARN_HD)};
  localparam logic [N_TEMP-1:0][TW-1:0] FATAL_DEF = {TW'(BRD_FATAL_HD), TW'(FPGA_FATAL_HD)};

  logic [N_SUP-1:0][VW-1:0]  sup_mv;
  logic [N_SUP-1:0]          sup_vld;
  logic [N_TEMP-1:0][TW-1:0] tmp_val;
  logic [N_TEMP-1:0]         tmp_vld;
  logic [N_TEMP-1:0][TW-1:0] warn_lim, fatal_lim;
  logic [N_FATAL-1:0]        fatal_vec;
  logic [N_TEMP-1:0]         warn_vec;

  assign sup_mv  = {edge_mv, aux_mv};
  assign sup_vld = {edge_vld, aux_vld};
  assign tmp_val = {brd_temp, fpga_temp};
  assign tmp_vld = {brd_vld, fpga_vld};

  tlm_limit_regs #(
    .TW(TW), .WARN_DEF(WARN_DEF), .FATAL_DEF(FATAL_DEF)
  ) u_lims (
    .clk(clk), .rst(rst), .we(lim_we), .sel(lim_sel), .wdata(lim_wdata),
    .warn_lim(warn_lim), .fatal_lim(fatal_lim)
  );

  for (genvar i = 0; i < N_SUP; i++) begin : g_sup
    tlm_uv_chan #(.VW(VW), .UV_MV(UV_MV)) u_uv (
      .clk(clk), .rst(rst), .sample(sup_mv[i]), .vld(sup_vld[i]),
      .fatal(fatal_vec[i])
    );
  end

  for (genvar j = 0; j < N_TEMP; j++) begin : g_tmp
    tlm_ot_chan #(.TW(TW)) u_ot (
      .clk(clk), .rst(rst), .sample(tmp_val[j]), .vld(tmp_vld[j]),
      .warn_lim(warn_lim[j]), .fatal_lim(fatal_lim[j]),
      .warn(warn_vec[j]), .fatal(fatal_vec[N_SUP+j])
    );
  end

  tlm_trip_latch #(.NF(N_FATAL)) u_trip (
    .clk(clk), .rst(rst), .fatal(fatal_vec), .clr(clr_trip),
    .shutdown(shutdown_req), .cause(trip_cause)
  );

  assign warn_flags  = warn_vec;
  assign fatal_flags = fatal_vec;
endmodule

// File: rtl/tlm_guard_chk.sv
module tlm_guard_chk #(
  parameter int VW    = 16,
  parameter int UV_MV = 10460
) (
  input logic          clk,
  input logic          rst,
  input logic [VW-1:0] aux_mv,
  input logic          aux_vld,
  input logic          clr_trip,
  input logic [1:0]    warn_flags,
  input logic [3:0]    fatal_flags,
  input logic          shutdown_req,
  input logic [3:0]    trip_cause
);
  AST_UV_TRIP: assert property (@(posedge clk) disable iff (rst)
    (aux_vld && (aux_mv < VW'(UV_MV))) |=> fatal_flags[0]); // R2

  AST_INVALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !aux_vld |=> $stable(fatal_flags[0])); // R8

  AST_WARN_NO_SHDN: assert property (@(posedge clk) disable iff (rst)
    ((|warn_flags) && (fatal_flags == 4'd0) && !shutdown_req) |=> !shutdown_req); // R5

  AST_SHDN_SETS: assert property (@(posedge clk) disable iff (rst)
    (|fatal_flags) |=> shutdown_req); // R9

  AST_SHDN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (shutdown_req && !clr_trip) |=> shutdown_req); // R9

  AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (shutdown_req && clr_trip && (|fatal_flags)) |=> shutdown_req); // R10

  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (shutdown_req && clr_trip && (fatal_flags == 4'd0)) |=> !shutdown_req); // R10

  AST_CAUSE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (shutdown_req && !clr_trip) |=> $stable(trip_cause)); // R11

  AST_CAUSE_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !shutdown_req |-> (trip_cause == 4'd0)); // R11
endmodule

bind tlm_guard tlm_guard_chk #(.VW(VW), .UV_MV(UV_MV)) u_chk (
  .clk(clk), .rst(rst), .aux_mv(aux_mv), .aux_vld(aux_vld),
  .clr_trip(clr_trip), .warn_flags(warn_flags), .fatal_flags(fatal_flags),
  .shutdown_req(shutdown_req), .trip_cause(trip_cause)
);

// File: tb/tlm_guard_bench.sv
module tlm_guard_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] aux_mv = 16'd12000, edge_mv = 16'd12000;
  logic        aux_vld = 1'b1, edge_vld = 1'b1;
  logic [15:0] fpga_temp = 16'd100, brd_temp = 16'd80;
  logic        fpga_vld = 1'b1, brd_vld = 1'b1;
  logic        lim_we = 1'b0;
  logic [1:0]  lim_sel = 2'd0;
  logic [15:0] lim_wdata = 16'd0;
  logic        clr_trip = 1'b0;
  logic [1:0]  warn_flags;
  logic [3:0]  fatal_flags;
  logic        shutdown_req;
  logic [3:0]  trip_cause;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tlm_guard u_tlm_guard (
    .clk(clk), .rst(rst), .aux_mv(aux_mv), .aux_vld(aux_vld),
    .edge_mv(edge_mv), .edge_vld(edge_vld), .fpga_temp(fpga_temp),
    .fpga_vld(fpga_vld), .brd_temp(brd_temp), .brd_vld(brd_vld),
    .lim_we(lim_we), .lim_sel(lim_sel), .lim_wdata(lim_wdata),
    .clr_trip(clr_trip), .warn_flags(warn_flags), .fatal_flags(fatal_flags),
    .shutdown_req(shutdown_req), .trip_cause(trip_cause)
  );

  // Behavioural reference model
  int       m_lim[4];
  bit [3:0] m_fat;
  bit [1:0] m_warn;
  bit       m_shd;
  bit [3:0] m_cause;

  always @(posedge clk) begin
    if (rst) begin
      m_lim[0] = 180; m_lim[1] = 200; m_lim[2] = 150; m_lim[3] = 170;
      m_fat = 0; m_warn = 0; m_shd = 0; m_cause = 0;
    end else begin
      if (!m_shd && m_fat != 0) begin
        m_shd = 1; m_cause = m_fat;
      end else if (m_shd && clr_trip && m_fat == 0) begin
        m_shd = 0; m_cause = 0;
      end
      if (aux_vld)  m_fat[0] = (int'(aux_mv) < 10460);
      if (edge_vld) m_fat[1] = (int'(edge_mv) < 10460);
      if (fpga_vld) begin
        m_fat[2]  = (int'($signed(fpga_temp)) >= m_lim[1]);
        m_warn[0] = (int'($signed(fpga_temp)) >= m_lim[0]);
      end
      if (brd_vld) begin
        m_fat[3]  = (int'($signed(brd_temp)) >= m_lim[3]);
        m_warn[1] = (int'($signed(brd_temp)) >= m_lim[2]);
      end
      if (lim_we) m_lim[lim_sel] = int'($signed(lim_wdata));
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2/R3/R4 fatal_flags", int'(fatal_flags), int'(m_fat));
      chk("R5 warn_flags", int'(warn_flags), int'(m_warn));
      chk("R9 shutdown_req", int'(shutdown_req), int'(m_shd));
      chk("R11 trip_cause", int'(trip_cause), int'(m_cause));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic nominal();
    aux_mv = 16'd12000; edge_mv = 16'd12000;
    fpga_temp = 16'd100; brd_temp = 16'd80;
    aux_vld = 1; edge_vld = 1; fpga_vld = 1; brd_vld = 1;
  endtask

  task automatic clear_trip();
    clr_trip = 1; tick(); clr_trip = 0;
  endtask

  task automatic wr_lim(logic [1:0] s, int v);
    lim_we = 1; lim_sel = s; lim_wdata = 16'(v); tick(); lim_we = 0;
  endtask

  initial begin
    tick(3);
    chk("R1 reset fatal", int'(fatal_flags), 0);
    chk("R1 reset shutdown", int'(shutdown_req), 0);
    rst = 0;
    tick(2);
    chk("R1 after reset warn", int'(warn_flags), 0);
    chk("R1 after reset cause", int'(trip_cause), 0);

    // R2 boundary on auxiliary input
    aux_mv = 16'd10460; tick(2);
    chk("R2 10460 no trip", int'(fatal_flags), 0);
    aux_mv = 16'd10459; tick();
    chk("R2 10459 trips", int'(fatal_flags), 1);
    chk("R9 not yet latched", int'(shutdown_req), 0);
    tick();
    chk("R9 latched", int'(shutdown_req), 1);
    chk("R11 cause aux", int'(trip_cause), 1);
    aux_mv = 16'd12000; tick(2);
    chk("R9 stays after fault clears", int'(shutdown_req), 1);
    // R10 clear blocked by live edge fault
    edge_mv = 16'd9000; tick();
    chk("R2 edge trips", int'(fatal_flags), 2);
    clear_trip(); tick();
    chk("R10 blocked clear", int'(shutdown_req), 1);
    chk("R11 cause kept", int'(trip_cause), 1);
    edge_mv = 16'd12000; tick();
    clear_trip();
    chk("R10 clear", int'(shutdown_req), 0);
    chk("R10 cause cleared", int'(trip_cause), 0);

    // R8 invalid sample ignored
    aux_vld = 0; aux_mv = 16'd5000; tick(3);
    chk("R8 invalid ignored", int'(fatal_flags), 0);
    chk("R8 no shutdown", int'(shutdown_req), 0);
    nominal(); tick();

    // R3 FPGA fatal boundary
    fpga_temp = 16'd199; tick(2);
    chk("R3 199 no fatal", int'(fatal_flags), 0);
    chk("R5 199 warn", int'(warn_flags), 1);
    fpga_temp = 16'd200; tick(2);
    chk("R3 200 fatal", int'(fatal_flags), 4);
    chk("R11 cause fpga", int'(trip_cause), 4);
    nominal(); tick(); clear_trip();

    // R5 board warning only
    brd_temp = 16'd150; tick(3);
    chk("R5 board warn", int'(warn_flags), 2);
    chk("R5 warn no shutdown", int'(shutdown_req), 0);
    brd_temp = 16'd149; tick();
    chk("R5 149 no warn", int'(warn_flags), 0);

    // R4 board fatal
    brd_temp = 16'd170; tick(2);
    chk("R4 board fatal", int'(fatal_flags), 8);
    chk("R11 cause board", int'(trip_cause), 8);
    nominal(); tick(); clear_trip();

    // R6 negative reading
    fpga_temp = -16'sd300; brd_temp = -16'sd1; tick(3);
    chk("R6 negative no fatal", int'(fatal_flags), 0);
    chk("R6 negative no warn", int'(warn_flags), 0);
    nominal(); tick();

    // R7 limit writes, sample in write cycle uses old limit
    fpga_temp = 16'd120;
    wr_lim(2'd1, 120);
    chk("R7 old limit in write cycle", int'(fatal_flags), 0);
    tick();
    chk("R7 new fatal limit", int'(fatal_flags), 4);
    fpga_temp = 16'd119; tick();
    chk("R7 below new limit", int'(fatal_flags), 0);
    wr_lim(2'd1, 200); clear_trip();
    wr_lim(2'd2, 100); brd_temp = 16'd100; tick(2);
    chk("R7 board warn limit", int'(warn_flags), 2);
    wr_lim(2'd2, 150); nominal(); tick(2);

    // R11 simultaneous causes
    aux_mv = 16'd9000; brd_temp = 16'd170; tick(2);
    chk("R11 simultaneous cause", int'(trip_cause), 9);
    nominal(); tick(); clear_trip();

    // Randomized phase checked against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      aux_mv    = 16'(9500 + $urandom_range(0, 2500));
      edge_mv   = 16'(9500 + $urandom_range(0, 2500));
      fpga_temp = 16'($signed(int'($urandom_range(0, 320)) - 60));
      brd_temp  = 16'($signed(int'($urandom_range(0, 260)) - 60));
      aux_vld   = ($urandom_range(0, 9) != 0);
      edge_vld  = ($urandom_range(0, 9) != 0);
      fpga_vld  = ($urandom_range(0, 9) != 0);
      brd_vld   = ($urandom_range(0, 9) != 0);
      clr_trip  = ($urandom_range(0, 7) == 0);
      lim_we    = ($urandom_range(0, 29) == 0);
      lim_sel   = 2'($urandom_range(0, 3));
      lim_wdata = 16'(100 + $urandom_range(0, 140));
      tick();
    end
    lim_we = 0; clr_trip = 0;
    tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule